// File: doc/BRIEF.md
# Context-Tagged Guest-Physical Translation Cache

This block holds up to eight final second-level address translations. Each translation maps a guest-physical page to a host-physical page. Every entry is tagged by two things: the address field of a context pointer together with that pointer's accessed/dirty enable bit, and a guest-physical page number. The page may be 4 KB, 2 MB or 1 GB, and the tag compares only the address bits above the page offset. A lookup supplies a context pointer, a guest-physical address and the requested access kinds. One cycle later the block answers with exactly one of three outcomes: hit, miss or permission violation. On a hit it also returns the host-physical address, the permissions, the memory type, the type-override flag and the page size.

Entries are installed from a page-walk result through a fill port. The fill port carries the leaf entry and the level at which the walk stopped. Entries that are not present or are misconfigured are dropped. Entries can be removed in three ways:
- by a single-context invalidation keyed on a context pointer's address field;
- by an all-context invalidation;
- automatically, when a lookup matches but lacks the requested permission. The retried access then misses and can be rewalked.

Top module: `gpa_xlate_cache`

## Requirements
- R1: For every cycle with `lk_valid_i` high, the next cycle has `rsp_valid_o` high with exactly one of `rsp_hit_o`, `rsp_miss_o`, `rsp_viol_o` set. In all other cycles all four are low. A lookup sees the contents as they were before any update made in its own cycle.
- R2: The fields returned come from the leaf entry (bit positions below are in the leaf entry).
  - A hit returns `rsp_perm_o` from bits 2:0: bit 0 is read, bit 1 is write, bit 2 is execute.
  - `rsp_mtype_o` comes from bits 5:3 and `rsp_ovr_o` from bit 6.
  - `rsp_hpa_o` is the frame in bits 51:12 joined with the page-offset bits of the guest address.
- R3: `fl_level_i` selects the page size, and `rsp_size_o` reports it with the codes 0 = 4 KB, 1 = 2 MB, 2 = 1 GB.
  - Level 1 gives a 4 KB page. A lookup matches guest bits 47:12, and `rsp_hpa_o` takes guest bits 11:0.
  - Level 2 with entry bit 7 set gives a 2 MB page. It matches bits 47:21, and `rsp_hpa_o` takes guest bits 20:0.
  - Level 3 with entry bit 7 set gives a 1 GB page. It matches bits 47:30, and `rsp_hpa_o` takes guest bits 29:0.
- R4: A fill creates no entry in any of these cases:
  - bits 2:0 are all zero;
  - write is granted without read (bits 2:0 equal 010 or 110);
  - bits 5:3 hold memory type 2, 3 or 7;
  - the level is 0;
  - the level is 2 or 3 with bit 7 clear.
- R5: A matching lookup whose requested access bits in `lk_acc_i` (same encoding as R2) are not all granted reports `rsp_viol_o`, with the entry's permissions on `rsp_perm_o`. That entry is invalidated, so an identical later lookup misses.
- R6: The context tag is bits 51:12 of the context pointer plus bit 6. A lookup whose pointer differs from the filling pointer only in bit 6 misses. A lookup with a different address field also misses.
- R7: A single-context invalidation (`inv_single_i`) removes every entry whose tag address equals bits 51:12 of `inv_ctx_i`, whatever its bit-6 value. Entries with other context addresses still hit.
- R8: An all-context invalidation (`inv_all_i`) empties the cache at one clock edge. A lookup in the following cycle misses.
- R9: When `inv_single_i` or `inv_all_i` is high, a fill in the same cycle is discarded.
- R10: A fill whose context tag and guest address match an existing valid entry overwrites that entry instead of taking a new one.
- R11: A new fill goes into the lowest-numbered invalid entry. When all entries are valid, it replaces the entry at a round-robin pointer.
  - The pointer is 0 after reset and advances by one, wrapping, after each such replacement.
  - Invalidations and overwrites leave the pointer unchanged.
- R12: After reset the cache is empty, so every lookup misses, and no response is flagged until a lookup arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_ctx_i | input | 64 | Lookup context pointer |
| lk_gpa_i | input | 48 | Lookup guest-physical address |
| lk_acc_i | input | 3 | Requested access: bit 0 read, bit 1 write, bit 2 execute |
| fl_valid_i | input | 1 | Fill request |
| fl_ctx_i | input | 64 | Fill context pointer |
| fl_gpa_i | input | 48 | Fill guest-physical address |
| fl_level_i | input | 2 | Level at which the walk found the leaf (1..3) |
| fl_entry_i | input | 64 | Leaf entry from the walk |
| inv_single_i | input | 1 | Single-context invalidation |
| inv_all_i | input | 1 | All-context invalidation |
| inv_ctx_i | input | 64 | Context pointer for single-context invalidation |
| rsp_valid_o | output | 1 | Response valid |
| rsp_hit_o | output | 1 | Lookup hit with access granted |
| rsp_miss_o | output | 1 | Lookup missed |
| rsp_viol_o | output | 1 | Lookup matched but access denied |
| rsp_hpa_o | output | 52 | Host-physical address |
| rsp_perm_o | output | 3 | Entry permissions |
| rsp_mtype_o | output | 3 | Memory type |
| rsp_ovr_o | output | 1 | Memory-type override flag |
| rsp_size_o | output | 2 | Page size code |

## Verification
Lookups are made at addresses inside and just outside 4 KB, 2 MB and 1 GB pages, which separates correct offset masking from over- or under-matching. Each context pointer is paired with a second pointer that differs only in the accessed/dirty bit and with a third that has another address field, which shows whether the tag uses both fields. Lookups ask for subsets of access kinds, both within and beyond the granted permissions, and each is followed by a retry; this separates a correct eviction from a sticky entry. Fill sequences run past eight entries, and fills that repeat a cached page reveal whether replacement picks free slots first, follows the round-robin order, and overwrites in place rather than duplicating.

// File: rtl/gxc_pkg.sv
package gxc_pkg;
  localparam int FRAME_W = 40;           // leaf bits 51:12
  localparam int CTX_AW  = 40;           // context pointer bits 51:12
  localparam int PA_W    = FRAME_W + 12;
  localparam int SH_2M   = 9;            // page-number bits below a 2 MB page
  localparam int SH_1G   = 18;

  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_1G = 2'd2
  } pg_size_e;

  typedef struct packed {
    logic [FRAME_W-1:0] pfn;
    logic [2:0]         perm;
    logic [2:0]         mtype;
    logic               ovr;
    pg_size_e           size;
  } leaf_attr_t;

  typedef struct packed {
    logic [CTX_AW-1:0] addr;
    logic              ad;
  } ctx_tag_t;
endpackage

// File: rtl/gxc_leaf_decode.sv
module gxc_leaf_decode
  import gxc_pkg::*;
(
  input  logic        fl_valid_i,
  input  logic [1:0]  fl_level_i,
  input  logic [63:0] fl_entry_i,
  output logic        fill_ok_o,
  output leaf_attr_t  attr_o
);
  logic       present, wr_no_rd, bad_mt, is_leaf;
  logic [2:0] mt;
  pg_size_e   sz;

  assign mt       = fl_entry_i[5:3];
  assign present  = |fl_entry_i[2:0];
  assign wr_no_rd = fl_entry_i[1] & ~fl_entry_i[0];
  assign bad_mt   = (mt == 3'd2) | (mt == 3'd3) | (mt == 3'd7);

  always_comb begin
    is_leaf = 1'b0;
    sz      = PG_4K;
    unique case (fl_level_i)
      2'd1: is_leaf = 1'b1;
      2'd2: begin is_leaf = fl_entry_i[7]; sz = PG_2M; end
      2'd3: begin is_leaf = fl_entry_i[7]; sz = PG_1G; end
      default: is_leaf = 1'b0;
    endcase
  end

  assign fill_ok_o = fl_valid_i & present & ~wr_no_rd & ~bad_mt & is_leaf;

  assign attr_o.pfn   = fl_entry_i[51:12];
  assign attr_o.perm  = fl_entry_i[2:0];
  assign attr_o.mtype = mt;
  assign attr_o.ovr   = fl_entry_i[6];
  assign attr_o.size  = sz;

  logic unused_entry_bits;
  assign unused_entry_bits = ^{fl_entry_i[63:52], fl_entry_i[11:8]};
endmodule

// File: rtl/gxc_tag_match.sv
module gxc_tag_match
  import gxc_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int VPN_W   = 36
) (
  input  logic [NUM_ENT-1:0]            vld_i,
  input  ctx_tag_t [NUM_ENT-1:0]        ctx_i,
  input  logic [NUM_ENT-1:0][VPN_W-1:0] vpn_i,
  input  pg_size_e [NUM_ENT-1:0]        size_i,
  input  ctx_tag_t                      req_ctx_i,
  input  logic [VPN_W-1:0]              req_vpn_i,
  output logic [NUM_ENT-1:0]            hit_o
);
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic [VPN_W-1:0] mask;
    always_comb begin
      unique case (size_i[g])
        PG_2M:   mask = {VPN_W{1'b1}} << SH_2M;
        PG_1G:   mask = {VPN_W{1'b1}} << SH_1G;
        default: mask = {VPN_W{1'b1}};
      endcase
    end
    assign hit_o[g] = vld_i[g] & (ctx_i[g] == req_ctx_i) &
                      (((vpn_i[g] ^ req_vpn_i) & mask) == '0);
  end
endmodule

// File: rtl/gxc_victim.sv
module gxc_victim #(
  parameter int NUM_ENT = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_ENT-1:0]         vld_i,
  input  logic [NUM_ENT-1:0]         dup_i,
  input  logic                       alloc_i,
  output logic [$clog2(NUM_ENT)-1:0] idx_o
);
  localparam int IDX_W = $clog2(NUM_ENT);

  logic [IDX_W-1:0] rr_q, first_free, first_dup;
  logic             has_free, has_dup;

  always_comb begin
    first_free = '0;
    first_dup  = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (!vld_i[i]) first_free = IDX_W'(i);
      if (dup_i[i])  first_dup  = IDX_W'(i);
    end
  end

  assign has_free = ~&vld_i;
  assign has_dup  = |dup_i;
  assign idx_o    = has_dup ? first_dup : (has_free ? first_free : rr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (alloc_i && !has_dup && !has_free) begin
      rr_q <= (rr_q == IDX_W'(NUM_ENT - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/gpa_xlate_cache.sv
module gpa_xlate_cache
  import gxc_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int GPA_W   = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [63:0]      lk_ctx_i,
  input  logic [GPA_W-1:0] lk_gpa_i,
  input  logic [2:0]       lk_acc_i,
  input  logic             fl_valid_i,
  input  logic [63:0]      fl_ctx_i,
  input  logic [GPA_W-1:0] fl_gpa_i,
  input  logic [1:0]       fl_level_i,
  input  logic [63:0]      fl_entry_i,
  input  logic             inv_single_i,
  input  logic             inv_all_i,
  input  logic [63:0]      inv_ctx_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic             rsp_miss_o,
  output logic             rsp_viol_o,
  output logic [PA_W-1:0]  rsp_hpa_o,
  output logic [2:0]       rsp_perm_o,
  output logic [2:0]       rsp_mtype_o,
  output logic             rsp_ovr_o,
  output logic [1:0]       rsp_size_o
);
  localparam int IDX_W = $clog2(NUM_ENT);
  localparam int VPN_W = GPA_W - 12;

  // storage
  logic [NUM_ENT-1:0]            vld_q, vld_d;
  ctx_tag_t [NUM_ENT-1:0]        tctx_q;
  logic [NUM_ENT-1:0][VPN_W-1:0] tvpn_q;
  leaf_attr_t [NUM_ENT-1:0]      attr_q;
  pg_size_e [NUM_ENT-1:0]        tsz;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_sz
    assign tsz[g] = attr_q[g].size;
  end

  ctx_tag_t lk_tag, fl_tag;
  assign lk_tag.addr = lk_ctx_i[51:12];
  assign lk_tag.ad   = lk_ctx_i[6];
  assign fl_tag.addr = fl_ctx_i[51:12];
  assign fl_tag.ad   = fl_ctx_i[6];

  // lookup compare
  logic [NUM_ENT-1:0] lk_hit;
  gxc_tag_match #(.NUM_ENT(NUM_ENT), .VPN_W(VPN_W)) u_lk_match (
    .vld_i     (vld_q),
    .ctx_i     (tctx_q),
    .vpn_i     (tvpn_q),
    .size_i    (tsz),
    .req_ctx_i (lk_tag),
    .req_vpn_i (lk_gpa_i[GPA_W-1:12]),
    .hit_o     (lk_hit)
  );

  // fill compare, used to overwrite instead of duplicating
  logic [NUM_ENT-1:0] fl_dup;
  gxc_tag_match #(.NUM_ENT(NUM_ENT), .VPN_W(VPN_W)) u_fl_match (
    .vld_i     (vld_q),
    .ctx_i     (tctx_q),
    .vpn_i     (tvpn_q),
    .size_i    (tsz),
    .req_ctx_i (fl_tag),
    .req_vpn_i (fl_gpa_i[GPA_W-1:12]),
    .hit_o     (fl_dup)
  );

  logic       fill_ok, fill_acc;
  leaf_attr_t fl_attr;
  gxc_leaf_decode u_dec (
    .fl_valid_i (fl_valid_i),
    .fl_level_i (fl_level_i),
    .fl_entry_i (fl_entry_i),
    .fill_ok_o  (fill_ok),
    .attr_o     (fl_attr)
  );

  assign fill_acc = fill_ok & ~inv_single_i & ~inv_all_i;

  logic [IDX_W-1:0] vic;
  gxc_victim #(.NUM_ENT(NUM_ENT)) u_vic (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (vld_q),
    .dup_i   (fl_dup),
    .alloc_i (fill_acc),
    .idx_o   (vic)
  );

  // lookup selection and permission check
  logic [IDX_W-1:0] lk_sel;
  logic             lk_any, acc_ok, viol_now;
  leaf_attr_t       sel_attr;

  always_comb begin
    lk_sel = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (lk_hit[i]) lk_sel = IDX_W'(i);
    end
  end

  assign lk_any   = |lk_hit;
  assign sel_attr = attr_q[lk_sel];
  assign acc_ok   = (lk_acc_i & ~sel_attr.perm) == 3'b000;
  assign viol_now = lk_valid_i & lk_any & ~acc_ok;

  logic [PA_W-1:0] off_mask, gpa_ext, hpa;
  always_comb begin
    unique case (sel_attr.size)
      PG_2M:   off_mask = {{(PA_W-21){1'b0}}, {21{1'b1}}};
      PG_1G:   off_mask = {{(PA_W-30){1'b0}}, {30{1'b1}}};
      default: off_mask = {{(PA_W-12){1'b0}}, {12{1'b1}}};
    endcase
  end
  assign gpa_ext = PA_W'(lk_gpa_i);
  assign hpa     = ({sel_attr.pfn, 12'h000} & ~off_mask) | (gpa_ext & off_mask);

  // valid-bit update: eviction, then invalidation, then fill
  always_comb begin
    vld_d = vld_q;
    if (viol_now) vld_d[lk_sel] = 1'b0;
    if (inv_all_i) begin
      vld_d = '0;
    end else if (inv_single_i) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (tctx_q[i].addr == inv_ctx_i[51:12]) vld_d[i] = 1'b0;
      end
    end else if (fill_ok) begin
      vld_d[vic] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      tctx_q <= '0;
      tvpn_q <= '0;
      attr_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (fill_acc) begin
        tctx_q[vic] <= fl_tag;
        tvpn_q[vic] <= fl_gpa_i[GPA_W-1:12];
        attr_q[vic] <= fl_attr;
      end
    end
  end

  // registered response
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_viol_o  <= 1'b0;
      rsp_hpa_o   <= '0;
      rsp_perm_o  <= '0;
      rsp_mtype_o <= '0;
      rsp_ovr_o   <= 1'b0;
      rsp_size_o  <= '0;
    end else begin
      rsp_valid_o <= lk_valid_i;
      rsp_hit_o   <= lk_valid_i & lk_any & acc_ok;
      rsp_miss_o  <= lk_valid_i & ~lk_any;
      rsp_viol_o  <= viol_now;
      if (lk_valid_i) begin
        rsp_hpa_o   <= hpa;
        rsp_perm_o  <= sel_attr.perm;
        rsp_mtype_o <= sel_attr.mtype;
        rsp_ovr_o   <= sel_attr.ovr;
        rsp_size_o  <= sel_attr.size;
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{lk_ctx_i[63:52], lk_ctx_i[11:7], lk_ctx_i[5:0],
                         fl_ctx_i[63:52], fl_ctx_i[11:7], fl_ctx_i[5:0],
                         inv_ctx_i[63:52], inv_ctx_i[11:0], fl_gpa_i[11:0]};
endmodule

// File: rtl/gxc_checker.sv
module gxc_checker #(
  parameter int NUM_ENT = 8,
  parameter int GPA_W   = 48
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lk_valid_i,
  input logic [63:0]        lk_ctx_i,
  input logic [GPA_W-1:0]   lk_gpa_i,
  input logic [2:0]         lk_acc_i,
  input logic               fl_valid_i,
  input logic               inv_all_i,
  input logic               rsp_valid_o,
  input logic               rsp_hit_o,
  input logic               rsp_miss_o,
  input logic               rsp_viol_o,
  input logic [2:0]         rsp_perm_o,
  input logic [1:0]         rsp_size_o,
  input logic [NUM_ENT-1:0] vld_q
);
  // R1
  a_r1_resp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> rsp_valid_o);
  a_r1_no_spurious_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !rsp_valid_o);
  a_r1_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($countones({rsp_hit_o, rsp_miss_o, rsp_viol_o}) == 1));
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(rsp_hit_o || rsp_miss_o || rsp_viol_o));
  // R3
  a_r3_size_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> (rsp_size_o != 2'd3));
  // R5
  a_r5_hit_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> (($past(lk_acc_i) & ~rsp_perm_o) == 3'b000));
  a_r5_viol_denied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_viol_o |-> (($past(lk_acc_i) & ~rsp_perm_o) != 3'b000));
  a_r5_retry_misses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_viol_o && lk_valid_i && !$past(fl_valid_i) &&
     lk_ctx_i == $past(lk_ctx_i) && lk_gpa_i == $past(lk_gpa_i) &&
     lk_acc_i == $past(lk_acc_i)) |=> rsp_miss_o);
  // R8
  a_r8_flush_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> (vld_q == '0));
endmodule

bind gpa_xlate_cache gxc_checker #(.NUM_ENT(NUM_ENT), .GPA_W(GPA_W)) u_gxc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lk_valid_i  (lk_valid_i),
  .lk_ctx_i    (lk_ctx_i),
  .lk_gpa_i    (lk_gpa_i),
  .lk_acc_i    (lk_acc_i),
  .fl_valid_i  (fl_valid_i),
  .inv_all_i   (inv_all_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_miss_o  (rsp_miss_o),
  .rsp_viol_o  (rsp_viol_o),
  .rsp_perm_o  (rsp_perm_o),
  .rsp_size_o  (rsp_size_o),
  .vld_q       (vld_q)
);

// File: tb/gpa_xlate_cache_tb_top.sv
`timescale 1ns/1ps
module gpa_xlate_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [63:0] lk_ctx = '0;
  logic [47:0] lk_gpa = '0;
  logic [2:0]  lk_acc = '0;
  logic        fl_valid = 1'b0;
  logic [63:0] fl_ctx = '0;
  logic [47:0] fl_gpa = '0;
  logic [1:0]  fl_level = '0;
  logic [63:0] fl_entry = '0;
  logic        inv_single = 1'b0;
  logic        inv_all = 1'b0;
  logic [63:0] inv_ctx = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_viol, rsp_ovr;
  logic [51:0] rsp_hpa;
  logic [2:0]  rsp_perm, rsp_mtype;
  logic [1:0]  rsp_size;

  int n_cmp = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  gpa_xlate_cache dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_ctx_i(lk_ctx), .lk_gpa_i(lk_gpa), .lk_acc_i(lk_acc),
    .fl_valid_i(fl_valid), .fl_ctx_i(fl_ctx), .fl_gpa_i(fl_gpa),
    .fl_level_i(fl_level), .fl_entry_i(fl_entry),
    .inv_single_i(inv_single), .inv_all_i(inv_all), .inv_ctx_i(inv_ctx),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss),
    .rsp_viol_o(rsp_viol), .rsp_hpa_o(rsp_hpa), .rsp_perm_o(rsp_perm),
    .rsp_mtype_o(rsp_mtype), .rsp_ovr_o(rsp_ovr), .rsp_size_o(rsp_size)
  );

  function automatic logic [63:0] mk_ctx(input logic [39:0] a, input logic ad);
    return {12'h000, a, 5'b00000, ad, 6'h1E};
  endfunction

  function automatic logic [63:0] mk_ent(input logic [39:0] pfn, input logic [2:0] perm,
                                         input logic [2:0] mt, input logic ovr,
                                         input logic big);
    return {12'h000, pfn, 4'h0, big, ovr, mt, perm};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [63:0] c, input logic [47:0] a, input logic [2:0] acc);
    @(negedge clk);
    lk_valid = 1'b1; lk_ctx = c; lk_gpa = a; lk_acc = acc;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic exp_hit(input string req, input logic [63:0] c, input logic [47:0] a,
                         input logic [2:0] acc, input logic [51:0] hpa,
                         input logic [2:0] perm, input logic [2:0] mt,
                         input logic ovr, input logic [1:0] sz);
    lookup(c, a, acc);
    chk(req, "hit", {63'b0, rsp_hit}, 64'd1);
    chk(req, "hpa", {12'b0, rsp_hpa}, {12'b0, hpa});
    chk(req, "perm", {61'b0, rsp_perm}, {61'b0, perm});
    chk(req, "mtype", {61'b0, rsp_mtype}, {61'b0, mt});
    chk(req, "ovr", {63'b0, rsp_ovr}, {63'b0, ovr});
    chk(req, "size", {62'b0, rsp_size}, {62'b0, sz});
  endtask

  task automatic exp_hit_only(input string req, input logic [63:0] c,
                              input logic [47:0] a, input logic [2:0] acc);
    lookup(c, a, acc);
    chk(req, "hit", {63'b0, rsp_hit}, 64'd1);
  endtask

  task automatic exp_miss(input string req, input logic [63:0] c, input logic [47:0] a,
                          input logic [2:0] acc);
    lookup(c, a, acc);
    chk(req, "flags{v,h,m,x}", {60'b0, rsp_valid, rsp_hit, rsp_miss, rsp_viol}, 64'b1010);
  endtask

  task automatic exp_viol(input string req, input logic [63:0] c, input logic [47:0] a,
                          input logic [2:0] acc, input logic [2:0] perm);
    lookup(c, a, acc);
    chk(req, "flags{v,h,m,x}", {60'b0, rsp_valid, rsp_hit, rsp_miss, rsp_viol}, 64'b1001);
    chk(req, "perm", {61'b0, rsp_perm}, {61'b0, perm});
  endtask

  task automatic drive(input logic all, input logic single, input logic [63:0] ic,
                       input logic f, input logic [63:0] fc, input logic [47:0] fa,
                       input logic [1:0] lvl, input logic [63:0] ent);
    @(negedge clk);
    inv_all = all; inv_single = single; inv_ctx = ic;
    fl_valid = f; fl_ctx = fc; fl_gpa = fa; fl_level = lvl; fl_entry = ent;
    @(negedge clk);
    inv_all = 1'b0; inv_single = 1'b0; fl_valid = 1'b0;
  endtask

  task automatic fill(input logic [63:0] c, input logic [47:0] a, input logic [1:0] lvl,
                      input logic [63:0] ent);
    drive(1'b0, 1'b0, '0, 1'b1, c, a, lvl, ent);
  endtask

  task automatic flush_all();
    drive(1'b1, 1'b0, '0, 1'b0, '0, '0, 2'd0, '0);
  endtask

  logic [63:0] ctx_a, ctx_b0, ctx_b1, ctx_c;

  task automatic t_reset();
    @(negedge clk);
    chk("R12", "idle flags", {60'b0, rsp_valid, rsp_hit, rsp_miss, rsp_viol}, 64'b0);
    exp_miss("R12", ctx_a, 48'h0000_1234_5000, 3'b001);
    @(negedge clk);
    chk("R1", "valid drops", {63'b0, rsp_valid}, 64'd0);
  endtask

  task automatic t_basic();
    fill(ctx_a, 48'h0000_1234_5000, 2'd1, mk_ent(40'hABCDE, 3'b111, 3'd6, 1'b1, 1'b0));
    exp_hit("R2", ctx_a, 48'h0000_1234_5ABC, 3'b011, {40'hABCDE, 12'hABC},
            3'b111, 3'd6, 1'b1, 2'd0);
    exp_miss("R3", ctx_a, 48'h0000_1234_6000, 3'b001);
  endtask

  task automatic t_sizes();
    fill(ctx_a, 48'h0000_4020_0000, 2'd2, mk_ent(40'h8_0000, 3'b101, 3'd0, 1'b0, 1'b1));
    exp_hit("R3", ctx_a, 48'h0000_402F_F123, 3'b100, 52'h0_0000_800F_F123,
            3'b101, 3'd0, 1'b0, 2'd1);
    exp_miss("R3", ctx_a, 48'h0000_4040_0000, 3'b001);
    fill(ctx_a, 48'h0001_C000_0000, 2'd3, mk_ent(40'h40_0000, 3'b011, 3'd4, 1'b0, 1'b1));
    exp_hit("R3", ctx_a, 48'h0001_EABC_D123, 3'b001, 52'h0_0004_2ABC_D123,
            3'b011, 3'd4, 1'b0, 2'd2);
    exp_miss("R3", ctx_a, 48'h0002_0000_0000, 3'b001);
  endtask

  task automatic t_reject();
    fill(ctx_a, 48'h0000_5000_0000, 2'd1, mk_ent(40'h111, 3'b000, 3'd6, 1'b0, 1'b0));
    exp_miss("R4", ctx_a, 48'h0000_5000_0000, 3'b000);
    fill(ctx_a, 48'h0000_5000_1000, 2'd1, mk_ent(40'h112, 3'b010, 3'd6, 1'b0, 1'b0));
    exp_miss("R4", ctx_a, 48'h0000_5000_1000, 3'b000);
    fill(ctx_a, 48'h0000_5000_2000, 2'd1, mk_ent(40'h113, 3'b111, 3'd2, 1'b0, 1'b0));
    exp_miss("R4", ctx_a, 48'h0000_5000_2000, 3'b001);
    fill(ctx_a, 48'h0000_5020_0000, 2'd2, mk_ent(40'h114, 3'b111, 3'd6, 1'b0, 1'b0));
    exp_miss("R4", ctx_a, 48'h0000_5020_0000, 3'b001);
    fill(ctx_a, 48'h0000_5000_3000, 2'd0, mk_ent(40'h115, 3'b111, 3'd6, 1'b0, 1'b0));
    exp_miss("R4", ctx_a, 48'h0000_5000_3000, 3'b001);
  endtask

  task automatic t_perm();
    fill(ctx_a, 48'h0000_6000_0000, 2'd1, mk_ent(40'h600, 3'b001, 3'd6, 1'b0, 1'b0));
    exp_viol("R5", ctx_a, 48'h0000_6000_0010, 3'b010, 3'b001);
    exp_miss("R5", ctx_a, 48'h0000_6000_0010, 3'b010);
    fill(ctx_a, 48'h0000_6000_1000, 2'd1, mk_ent(40'h601, 3'b100, 3'd6, 1'b0, 1'b0));
    exp_hit_only("R5", ctx_a, 48'h0000_6000_1000, 3'b100);
    exp_viol("R5", ctx_a, 48'h0000_6000_1000, 3'b001, 3'b100);
    exp_miss("R5", ctx_a, 48'h0000_6000_1000, 3'b001);
  endtask

  task automatic t_ctx();
    fill(ctx_b0, 48'h0000_7000_0000, 2'd1, mk_ent(40'h700, 3'b111, 3'd6, 1'b0, 1'b0));
    exp_miss("R6", ctx_b1, 48'h0000_7000_0000, 3'b001);
    exp_miss("R6", ctx_c, 48'h0000_7000_0000, 3'b001);
    exp_hit_only("R6", ctx_b0, 48'h0000_7000_0000, 3'b001);
    fill(ctx_b1, 48'h0000_7000_1000, 2'd1, mk_ent(40'h701, 3'b111, 3'd6, 1'b0, 1'b0));
    exp_hit_only("R6", ctx_b1, 48'h0000_7000_1000, 3'b001);
  endtask

  task automatic t_inv_single();
    drive(1'b0, 1'b1, ctx_b0, 1'b0, '0, '0, 2'd0, '0);
    exp_miss("R7", ctx_b0, 48'h0000_7000_0000, 3'b001);
    exp_miss("R7", ctx_b1, 48'h0000_7000_1000, 3'b001);
    exp_hit_only("R7", ctx_a, 48'h0000_1234_5000, 3'b001);
    exp_hit_only("R7", ctx_a, 48'h0000_4020_0000, 3'b001);
  endtask

  task automatic t_inv_all();
    flush_all();
    exp_miss("R8", ctx_a, 48'h0000_1234_5000, 3'b001);
    exp_miss("R8", ctx_a, 48'h0001_C000_0000, 3'b001);
  endtask

  task automatic t_inv_prio();
    drive(1'b1, 1'b0, '0, 1'b1, ctx_a, 48'h0000_8000_0000, 2'd1,
          mk_ent(40'h800, 3'b111, 3'd6, 1'b0, 1'b0));
    exp_miss("R9", ctx_a, 48'h0000_8000_0000, 3'b001);
    drive(1'b0, 1'b1, ctx_b0, 1'b1, ctx_a, 48'h0000_8000_1000, 2'd1,
          mk_ent(40'h801, 3'b111, 3'd6, 1'b0, 1'b0));
    exp_miss("R9", ctx_a, 48'h0000_8000_1000, 3'b001);
  endtask

  function automatic logic [47:0] pg(input int i);
    return 48'h0000_0010_0000 + (48'(i) << 12);
  endfunction

  task automatic t_repl();
    for (int i = 0; i < 8; i++)
      fill(ctx_a, pg(i), 2'd1, mk_ent(40'h200 + 40'(i), 3'b111, 3'd6, 1'b0, 1'b0));
    for (int i = 0; i < 8; i++) exp_hit_only("R11", ctx_a, pg(i), 3'b001);
    fill(ctx_a, pg(8), 2'd1, mk_ent(40'h208, 3'b111, 3'd6, 1'b0, 1'b0));
    exp_miss("R11", ctx_a, pg(0), 3'b001);
    exp_hit_only("R11", ctx_a, pg(1), 3'b001);
    exp_hit_only("R11", ctx_a, pg(8), 3'b001);
    fill(ctx_a, pg(9), 2'd1, mk_ent(40'h209, 3'b111, 3'd6, 1'b0, 1'b0));
    exp_miss("R11", ctx_a, pg(1), 3'b001);
    exp_hit_only("R11", ctx_a, pg(2), 3'b001);
  endtask

  // round-robin pointer is 2 here (two replacements so far)
  task automatic t_dup();
    flush_all();
    for (int i = 0; i < 7; i++)
      fill(ctx_a, pg(i), 2'd1, mk_ent(40'h300 + 40'(i), 3'b111, 3'd6, 1'b0, 1'b0));
    fill(ctx_a, pg(2), 2'd1, mk_ent(40'h999, 3'b001, 3'd0, 1'b0, 1'b0));
    exp_hit("R10", ctx_a, pg(2), 3'b001, {40'h999, 12'h000}, 3'b001, 3'd0, 1'b0, 2'd0);
    fill(ctx_a, pg(7), 2'd1, mk_ent(40'h307, 3'b111, 3'd6, 1'b0, 1'b0));
    for (int i = 0; i < 8; i++) exp_hit_only("R10", ctx_a, pg(i), 3'b001);
    fill(ctx_a, pg(8), 2'd1, mk_ent(40'h308, 3'b111, 3'd6, 1'b0, 1'b0));
    exp_miss("R10", ctx_a, pg(2), 3'b001);
    exp_hit_only("R10", ctx_a, pg(3), 3'b001);
    exp_hit_only("R11", ctx_a, pg(8), 3'b001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    ctx_a  = mk_ctx(40'h00_0001_2000, 1'b1);
    ctx_b0 = mk_ctx(40'h00_0003_4000, 1'b0);
    ctx_b1 = mk_ctx(40'h00_0003_4000, 1'b1);
    ctx_c  = mk_ctx(40'h00_0005_6000, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_sizes();
    t_reject();
    t_perm();
    t_ctx();
    t_inv_single();
    t_inv_all();
    t_inv_prio();
    t_repl();
    t_dup();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule